// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an internal request port and an external asynchronous static RAM of 256K words by 16 bits. A client presents one read or one write at a time on a valid/ready handshake, with a byte-enable bit per 8-bit lane. The controller turns each request into a timed sequence on the memory pins: an active-low chip enable, write enable, output enable and a strobe per byte lane, an address bus, and a data bus split into output value, output enable and input value.

Every interval the memory needs is a whole number of system clocks. The block derives each count at elaboration from the clock period and from nanosecond timing parameters, rounding up. Write pulses are long enough for both the minimum pulse width and the data setup. Reads hold the strobes until both the address access time and the output-enable access time have elapsed. After every read, a turnaround gap with the output enable released keeps the RAM's output from colliding with write data the controller might drive next. Completion of each request is marked by a one-cycle done pulse; for reads, the captured word comes with it.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_done is 0, mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n and mem_lb_n are 1, and mem_dq_oe is 0.
- R2: A write holds chip enable low with write enable high for one cycle. Write enable then goes low for WP = ceil(max(T_WP_NS, T_DS_NS)/CLK_NS) cycles (2 with the defaults), followed by one cycle with write enable high again. The data bus is driven throughout. rsp_done rises WP+2 rising edges after the accepting edge (4 with the defaults).
- R3: Byte enable bit 0 selects the lower lane, bits 7:0, through mem_lb_n. Bit 1 selects the upper lane, bits 15:8, through mem_ub_n. A strobe is low only while chip enable is low and its enable bit is set, and a write leaves the lanes whose bit is clear unchanged in memory.
- R4: A read holds chip enable and output enable low, with write enable high, for RD = ceil(max(T_AA_NS, T_RC_NS, T_OE_NS)/CLK_NS) cycles (3 with the defaults). The data input is captured on the last of those edges, and rsp_done with rsp_rdata appears RD rising edges after the accepting edge.
- R5: In the captured read word, the lanes whose byte-enable bit is clear read as zero.
- R6: Output enable is never low while mem_dq_oe is 1, and write enable is never low while output enable is low.
- R7: mem_addr does not change in any cycle in which write enable is low, nor at the edge where it falls.
- R8: After a read, output enable goes high and req_ready stays 0 for TURN = ceil(T_HZ_NS/CLK_NS) cycles (1 with the defaults), the done cycle included, before the next request can be taken. req_ready is 0 from acceptance until the operation ends.
- R9: rsp_done is high for exactly one cycle per request.
- R10: Each write-enable low pulse lasts at least WP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken when valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, bit 0 lower lane |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data driven to memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_i | input | DATA_W | Data returned from memory |

## Verification
The bench builds the controller with ADDR_W set to 6 and the default 10 ns clock and timing values. This yields a 2-cycle write pulse, a 3-cycle read access and a 1-cycle turnaround, and it keeps the full 64-word space small enough to write, merge by lane and read back in full. Its memory model accepts a write only when the pulse has spanned the required time. It returns valid data only after the access time has elapsed, so any shortened count leaves wrong data behind.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WADDR,
        ST_WPULSE,
        ST_WHOLD,
        ST_READ,
        ST_TURN
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drv;
    } strobe_t;

    localparam strobe_t STROBE_OFF = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t decode(input seq_state_e s);
        strobe_t o;
        o = STROBE_OFF;
        case (s)
            ST_WADDR:  o = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1};
            ST_WPULSE: o = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drv: 1'b1};
            ST_WHOLD:  o = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1};
            ST_READ:   o = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drv: 1'b0};
            default:   o = STROBE_OFF;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int WP_CYC   = 2,
    parameter int RD_CYC   = 3,
    parameter int TURN_CYC = 1,
    parameter int CW       = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  logic    req_write,
    output logic    req_ready,
    output logic    accept,
    output logic    capture,
    output logic    done,
    output strobe_t ctrl
);
    seq_state_e    state_q, state_d;
    logic          tload;
    logic [CW-1:0] tval;
    logic          tzero;
    logic          done_q;
    strobe_t       ctrl_q;
    logic [7:0]    wlen_q;

    asram_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tload),
        .load_val (tval),
        .zero     (tzero)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        tload   = 1'b0;
        tval    = '0;
        capture = 1'b0;
        case (state_q)
            ST_IDLE: if (accept) begin
                tload = 1'b1;
                if (req_write) begin
                    state_d = ST_WADDR;
                end else begin
                    state_d = ST_READ;
                    tval    = CW'(RD_CYC - 1);
                end
            end
            ST_WADDR: begin
                state_d = ST_WPULSE;
                tload   = 1'b1;
                tval    = CW'(WP_CYC - 1);
            end
            ST_WPULSE: if (tzero) state_d = ST_WHOLD;
            ST_WHOLD:  state_d = ST_IDLE;
            ST_READ: if (tzero) begin
                capture = 1'b1;
                state_d = ST_TURN;
                tload   = 1'b1;
                tval    = CW'(TURN_CYC - 1);
            end
            ST_TURN: if (tzero) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctrl_q  <= STROBE_OFF;
            done_q  <= 1'b0;
            wlen_q  <= '0;
        end else begin
            state_q <= state_d;
            ctrl_q  <= decode(state_d);
            done_q  <= capture || (state_q == ST_WHOLD);
            wlen_q  <= ctrl_q.we_n ? 8'd0 : ((wlen_q == 8'hFF) ? wlen_q : wlen_q + 8'd1);
        end
    end

    assign ctrl = ctrl_q;
    assign done = done_q;

    AST_OE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.oe_n |-> !ctrl_q.drv); // R6
    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.we_n |-> ctrl_q.oe_n); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R9
    AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.oe_n) |-> !req_ready); // R8
    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ctrl_q.ce_n && !ctrl_q.drv)); // R1
    AST_WP_MIN: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.we_n) |-> (int'(wlen_q) >= WP_CYC)); // R10
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath
    import asram_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int NLANE  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  strobe_t           ctrl,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [NLANE-1:0]  req_be,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [NLANE-1:0]  lane_n,
    output logic [DATA_W-1:0] rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [NLANE-1:0]  be_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        assign lane_n[l] = ctrl.ce_n || !be_q[l];
        always_ff @(posedge clk) begin
            if (rst)
                rdata_q[l*8 +: 8] <= '0;
            else if (capture)
                rdata_q[l*8 +: 8] <= be_q[l] ? mem_dq_i[l*8 +: 8] : 8'h00;
        end
    end

    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;
    assign rdata    = rdata_q;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctrl.we_n |-> $stable(addr_q)); // R7
    AST_LANE_IDLE: assert property (@(posedge clk) disable iff (rst)
        ctrl.ce_n |-> (lane_n == '1)); // R3
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 16,
    parameter int CLK_NS  = 10,
    parameter int T_WP_NS = 15,
    parameter int T_DS_NS = 10,
    parameter int T_AA_NS = 25,
    parameter int T_RC_NS = 25,
    parameter int T_OE_NS = 10,
    parameter int T_HZ_NS = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_be,
    output logic                  rsp_done,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  mem_ce_n,
    output logic                  mem_we_n,
    output logic                  mem_oe_n,
    output logic                  mem_ub_n,
    output logic                  mem_lb_n,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_dq_o,
    output logic                  mem_dq_oe,
    input  logic [DATA_W-1:0]     mem_dq_i
);
    localparam int NLANE    = DATA_W / 8;
    localparam int WP_CYC   = ns2cyc(imax(T_WP_NS, T_DS_NS), CLK_NS);
    localparam int RD_CYC   = ns2cyc(imax(imax(T_AA_NS, T_RC_NS), T_OE_NS), CLK_NS);
    localparam int TURN_CYC = ns2cyc(T_HZ_NS, CLK_NS);
    localparam int CW       = $clog2(imax(imax(WP_CYC, RD_CYC), TURN_CYC) + 1);

    logic             accept;
    logic             capture;
    strobe_t          ctrl;
    logic [NLANE-1:0] lane_n;

    asram_seq #(
        .WP_CYC   (WP_CYC),
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC),
        .CW       (CW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .done      (rsp_done),
        .ctrl      (ctrl)
    );

    asram_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NLANE  (NLANE)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .ctrl      (ctrl),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .mem_dq_i  (mem_dq_i),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .lane_n    (lane_n),
        .rdata     (rsp_rdata)
    );

    assign mem_ce_n  = ctrl.ce_n;
    assign mem_we_n  = ctrl.we_n;
    assign mem_oe_n  = ctrl.oe_n;
    assign mem_dq_oe = ctrl.drv;
    assign mem_lb_n  = lane_n[0];
    assign mem_ub_n  = lane_n[NLANE-1];
endmodule

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NW = 1 << AW;
    localparam int CLKP = 10;
    localparam int WP_EXP   = (15 + CLKP - 1) / CLKP;
    localparam int RD_EXP   = (25 + CLKP - 1) / CLKP;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0] req_be = '0;
    logic req_ready, rsp_done, ce_n, we_n, oe_n, ub_n, lb_n, dq_oe;
    logic [DW-1:0] rsp_rdata, dq_o, dq_i;
    logic [AW-1:0] maddr;

    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLKP)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_ce_n(ce_n), .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_ub_n(ub_n),
        .mem_lb_n(lb_n), .mem_addr(maddr), .mem_dq_o(dq_o), .mem_dq_oe(dq_oe),
        .mem_dq_i(dq_i)
    );

    // memory model: writes commit only after a long enough pulse, reads valid after access time
    logic [DW-1:0] mem [NW];
    int age = 0, wlen = 0, prot_bad = 0;
    logic [1:0] wstrb = '0;
    logic [DW-1:0] wdat = '0;
    logic [AW-1:0] waddr = '0, last_addr = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!oe_n && dq_oe) prot_bad++;
            if (!oe_n && !we_n) prot_bad++;
            if (!we_n && maddr != last_addr) prot_bad++;
        end
        last_addr = maddr;
        if (!ce_n && !oe_n && we_n) age++; else age = 0;
        if (!ce_n && !we_n) begin
            wlen++;
            wstrb = {~ub_n, ~lb_n};
            wdat  = dq_oe ? dq_o : 16'hE0E0;
            waddr = maddr;
        end else begin
            if (wlen >= WP_EXP) begin
                if (wstrb[0]) mem[waddr][7:0]  = wdat[7:0];
                if (wstrb[1]) mem[waddr][15:8] = wdat[15:8];
            end
            wlen = 0;
        end
    end

    always_comb begin
        dq_i = 16'h0F0F;
        if (!ce_n && !oe_n && we_n) begin
            if (age >= RD_EXP) begin
                dq_i[7:0]  = lb_n ? 8'hA5 : mem[maddr][7:0];
                dq_i[15:8] = ub_n ? 8'hA5 : mem[maddr][15:8];
            end else
                dq_i = 16'hBAD1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input int a, input logic [DW-1:0] d,
                         input logic [1:0] be, output logic [DW-1:0] rd, output int lat);
        int guard = 0;
        while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
        req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_be = be;
        @(posedge clk);
        #1 req_valid = 0;
        lat = 0;
        forever begin
            @(posedge clk); lat++;
            @(negedge clk);
            if (!wr && !rsp_done) chk(!req_ready, "R8 busy", req_ready, 0);
            if (rsp_done || lat > 40) break;
        end
        rd = rsp_rdata;
        if (lat > 40) chk(0, "R2/R4 watchdog", lat, 0);
    endtask

    function automatic logic [DW-1:0] pat1(input int a);
        return DW'(a * 2749 + 16'h1357);
    endfunction
    function automatic logic [DW-1:0] pat2(input int a);
        return ~pat1(a) ^ DW'(a << 3);
    endfunction
    function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                            input logic [1:0] be);
        return {be[1] ? n[15:8] : o[15:8], be[0] ? n[7:0] : o[7:0]};
    endfunction

    initial begin
        #1_000_000;
        failures++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        logic [DW-1:0] exp_mem [NW];
        int lat;
        for (int i = 0; i < NW; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !rsp_done && ce_n && we_n && oe_n && ub_n && lb_n && !dq_oe,
            "R1 reset", {req_ready, rsp_done, ce_n, we_n, oe_n, ub_n, lb_n, dq_oe}, 8'b10111110);
        rst = 0;
        @(negedge clk);

        // R2 full-word writes over every address
        for (int a = 0; a < NW; a++) begin
            do_op(1, a, pat1(a), 2'b11, rd, lat);
            exp_mem[a] = pat1(a);
            chk(lat == WP_EXP + 2, "R2 write latency", lat, WP_EXP + 2);
            chk(req_ready, "R8 ready after write", req_ready, 1);
        end
        // R4 read back every address
        for (int a = 0; a < NW; a++) begin
            do_op(0, a, '0, 2'b11, rd, lat);
            chk(lat == RD_EXP, "R4 read latency", lat, RD_EXP);
            chk(rd == exp_mem[a], "R4 read data", rd, exp_mem[a]);
            chk(!req_ready, "R8 turnaround", req_ready, 0);
            @(negedge clk);
            chk(req_ready, "R8 ready after turnaround", req_ready, 1);
        end
        // R3 lane writes: be cycles through 01,10,11
        for (int a = 0; a < NW; a++) begin
            logic [1:0] be = 2'(a % 3 + 1);
            do_op(1, a, pat2(a), be, rd, lat);
            exp_mem[a] = merge(exp_mem[a], pat2(a), be);
        end
        // R3/R5 read back with be cycling 00,01,10,11
        for (int a = 0; a < NW; a++) begin
            logic [1:0] be = 2'(a % 4);
            do_op(0, a, '0, be, rd, lat);
            chk(rd == merge(16'h0000, exp_mem[a], be), "R3 R5 lane read", rd,
                merge(16'h0000, exp_mem[a], be));
        end
        // back-to-back write after read, same address
        do_op(0, 5, '0, 2'b11, rd, lat);
        do_op(1, 5, 16'hC3A5, 2'b11, rd, lat);
        do_op(0, 5, '0, 2'b11, rd, lat);
        chk(rd == 16'hC3A5, "R8 write after read", rd, 16'hC3A5);
        // R9 done lasts one cycle
        @(negedge clk);
        chk(!rsp_done, "R9 done pulse", rsp_done, 0);
        // R6 R7 R10 protocol monitor
        chk(prot_bad == 0, "R6 R7 R10 pin protocol", prot_bad, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule